// File: doc/BRIEF.md
# Boot Vector Remap Controller

This block sits on the instruction fetch path and redirects any fetch that falls in the system vector window to a selectable physical region. The window is the lowest 512 bytes of the address map. A fetch inside it leaves with its nine low offset bits unchanged and its upper bits replaced by the active remap base. Any other fetch passes through unchanged.

A two-bit boot-select input is captured while reset is held. It chooses the reset-time vector source, which is either the loader ROM at 0x10_0000 or the application ROM at 0x00_0000. It also decides whether the vectors may be moved later. Firmware moves them by loading a target register and then strobing a trigger with the remap command code. The request is checked, the base is updated when the check passes, and a done strobe follows. A rejected request sets a sticky failure flag. The active base can always be read from a status word.

Top module: `vec_remap_ctrl`

## Requirements
- R1: After reset the vector base is 0x10_0000 when the latched boot select is 2'b00 or 2'b01 and 0x00_0000 when it is 2'b10 or 2'b11. Both fail_o and cmd_done_o are 0.
- R2: A fetch address whose bits [23:9] are all zero appears on fetch_addr_o as {active base bits [23:9], fetch_addr_i[8:0]} in the same cycle.
- R3: A fetch address with any of bits [23:9] set appears on fetch_addr_o unchanged.
- R4: In boot modes 2'b00 and 2'b10, a trigger with code 8'h2E and a target whose bits [8:0] are zero loads target bits [23:9] as the new base. The new base takes effect from the cycle after the trigger. The target may lie in application ROM, loader ROM or SRAM space.
- R5: In boot modes 2'b01 and 2'b11 every remap request is rejected. The base stays as it was and fail_o reads 1 from the next cycle.
- R6: A remap request whose target has any of bits [8:0] set is rejected. The base stays as it was and fail_o is set.
- R7: Each cycle in which cmd_trig_i is high is followed by exactly one cycle with cmd_done_o high. Back-to-back triggers keep cmd_done_o high for the same number of cycles.
- R8: fail_o stays set until a cycle with fail_clr_i high, after which it reads 0. If a new rejection occurs in the same cycle as the clear, the flag stays set.
- R9: boot_sel_i is sampled only while reset is in effect. Changing it afterwards has no effect on the base or on remap permission. Every reset reloads the base from the value sampled during that reset.
- R10: A trigger with any code other than 8'h2E changes no base and sets fail_o.
- R11: status_o carries the active base in bits [23:9]. All its other bits are 0.
- R12: A trigger uses the target register value held before that cycle. A target written in the same cycle as the trigger applies only to later triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| boot_sel_i | input | 2 | Boot mode, sampled during reset |
| fetch_addr_i | input | 24 | CPU fetch address |
| fetch_addr_o | output | 24 | Translated fetch address |
| tgt_wr_i | input | 1 | Load strobe for the target register |
| tgt_wdata_i | input | 24 | Remap target address |
| cmd_trig_i | input | 1 | Command trigger strobe |
| cmd_code_i | input | 8 | Command code |
| fail_clr_i | input | 1 | Writing 1 clears the failure flag |
| cmd_done_o | output | 1 | One-cycle completion strobe per trigger |
| fail_o | output | 1 | Sticky rejected-request flag |
| status_o | output | 32 | Active base in bits [23:9] |

## Verification
Translation is combinational, so the expected fetch result is due in the same cycle the address is driven. The effects of a trigger (new base, done strobe, failure flag) are due exactly one cycle after the trigger cycle. The bench's reference model records the expectation for each cycle before it applies that cycle's inputs to its own state. Every trigger outcome is therefore compared in the following cycle and never earlier. Inputs are driven just after the rising edge and outputs are compared at the falling edge, which keeps both away from the capture point.

// File: rtl/vrm_pkg.sv
package vrm_pkg;

  typedef enum logic [1:0] {
    BOOT_LDR_IAP = 2'b00,
    BOOT_LDR_FIX = 2'b01,
    BOOT_APP_IAP = 2'b10,
    BOOT_APP_FIX = 2'b11
  } boot_mode_e;

  localparam logic [7:0] CMD_VEC_REMAP = 8'h2E;

  // bit 0 of the mode marks the fixed-vector variants
  function automatic logic remap_allowed(input boot_mode_e mode);
    return ~mode[0];
  endfunction

  // bit 1 of the mode selects application ROM as reset vector source
  function automatic logic boot_from_app(input boot_mode_e mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/vrm_rst_sync.sv
module vrm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n,
  output logic samp_en
);

  logic [STAGES-1:0] sync_q;
  logic              samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  // separate flop that mirrors the inverse of the released reset,
  // used only as a synchronous load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
    end else begin
      samp_q <= ~sync_q[STAGES-2];
    end
  end

  assign rst_s_n = sync_q[STAGES-1];
  assign samp_en = samp_q;

endmodule

// File: rtl/vrm_xlate.sv
module vrm_xlate #(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 9,
  localparam int BASE_W  = ADDR_W - WIN_BITS
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic in_window;

  always_comb begin
    in_window = (addr_i[ADDR_W-1:WIN_BITS] == '0);
    if (in_window) begin
      addr_o = {base_i, addr_i[WIN_BITS-1:0]};
    end else begin
      addr_o = addr_i;
    end
  end

endmodule

// File: rtl/vrm_cmd_unit.sv
module vrm_cmd_unit
  import vrm_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter int              WIN_BITS = 9,
  parameter int              CODE_W   = 8,
  parameter logic [ADDR_W-1:0] LDR_BASE = 24'h10_0000,
  parameter logic [ADDR_W-1:0] APP_BASE = 24'h00_0000,
  localparam int             BASE_W   = ADDR_W - WIN_BITS
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              samp_en,
  input  logic [1:0]        boot_sel_i,
  input  logic              tgt_wr_i,
  input  logic [ADDR_W-1:0] tgt_wdata_i,
  input  logic              cmd_trig_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              fail_clr_i,
  output logic [BASE_W-1:0] base_o,
  output boot_mode_e        boot_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              fail_o,
  output logic              done_o
);

  localparam logic [BASE_W-1:0] LDR_FIELD = LDR_BASE[ADDR_W-1:WIN_BITS];
  localparam logic [BASE_W-1:0] APP_FIELD = APP_BASE[ADDR_W-1:WIN_BITS];

  boot_mode_e        boot_q;
  logic [BASE_W-1:0] base_q, base_n, base_dflt;
  logic              base_we;
  logic [ADDR_W-1:0] tgt_q;
  logic              fail_q, fail_n;
  logic              done_q;
  logic              is_remap, aligned, accept, reject;

  // boot default chosen from the pin value seen during reset
  always_comb begin
    if (boot_from_app(boot_mode_e'(boot_sel_i))) begin
      base_dflt = APP_FIELD;
    end else begin
      base_dflt = LDR_FIELD;
    end
  end

  // request check and next state
  always_comb begin
    is_remap = (cmd_code_i == CODE_W'(CMD_VEC_REMAP));
    aligned  = (tgt_q[WIN_BITS-1:0] == '0);
    accept   = cmd_trig_i & is_remap & aligned & remap_allowed(boot_q);
    reject   = cmd_trig_i & ~accept;
    base_we  = accept;
    base_n   = tgt_q[ADDR_W-1:WIN_BITS];
    fail_n   = reject | (fail_q & ~fail_clr_i);
  end

  // boot mode: clock-enabled capture while reset is held
  always_ff @(posedge clk) begin
    if (samp_en) begin
      boot_q <= boot_mode_e'(boot_sel_i);
    end
  end

  // base: reload on reset, else load on accepted request
  always_ff @(posedge clk) begin
    if (samp_en) begin
      base_q <= base_dflt;
    end else if (base_we) begin
      base_q <= base_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tgt_q <= '0;
    end else if (tgt_wr_i) begin
      tgt_q <= tgt_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fail_q <= fail_n;
      done_q <= cmd_trig_i;
    end
  end

  assign base_o = base_q;
  assign boot_o = boot_q;
  assign tgt_o  = tgt_q;
  assign fail_o = fail_q;
  assign done_o = done_q;

endmodule

// File: rtl/vec_remap_ctrl.sv
module vec_remap_ctrl
  import vrm_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                WIN_BITS    = 9,
  parameter int                CODE_W      = 8,
  parameter int                STAT_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LDR_BASE    = 24'h10_0000,
  parameter logic [ADDR_W-1:0] APP_BASE    = 24'h00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sel_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              tgt_wr_i,
  input  logic [ADDR_W-1:0] tgt_wdata_i,
  input  logic              cmd_trig_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              fail_clr_i,
  output logic              cmd_done_o,
  output logic              fail_o,
  output logic [STAT_W-1:0] status_o
);

  localparam int BASE_W = ADDR_W - WIN_BITS;

  logic              rst_s_n;
  logic              samp_en;
  logic [BASE_W-1:0] base;
  boot_mode_e        boot_q;
  logic [ADDR_W-1:0] tgt_q;

  vrm_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n),
    .samp_en (samp_en)
  );

  vrm_cmd_unit #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .CODE_W   (CODE_W),
    .LDR_BASE (LDR_BASE),
    .APP_BASE (APP_BASE)
  ) cmd_i (
    .clk         (clk),
    .rst_s_n     (rst_s_n),
    .samp_en     (samp_en),
    .boot_sel_i  (boot_sel_i),
    .tgt_wr_i    (tgt_wr_i),
    .tgt_wdata_i (tgt_wdata_i),
    .cmd_trig_i  (cmd_trig_i),
    .cmd_code_i  (cmd_code_i),
    .fail_clr_i  (fail_clr_i),
    .base_o      (base),
    .boot_o      (boot_q),
    .tgt_o       (tgt_q),
    .fail_o      (fail_o),
    .done_o      (cmd_done_o)
  );

  vrm_xlate #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) xlate_i (
    .base_i (base),
    .addr_i (fetch_addr_i),
    .addr_o (fetch_addr_o)
  );

  // status packing: base field at its address bit positions
  generate
    if (STAT_W > ADDR_W) begin : g_stat_wide
      assign status_o = {{(STAT_W-ADDR_W){1'b0}}, base, {WIN_BITS{1'b0}}};
    end else begin : g_stat_exact
      assign status_o = {base, {WIN_BITS{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/vrm_chk.sv
module vrm_chk #(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 9,
  parameter int STAT_W   = 32
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic [1:0]        boot_q,
  input logic [ADDR_W-1:0] tgt_q,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              cmd_trig_i,
  input logic              fail_clr_i,
  input logic              cmd_done_o,
  input logic              fail_o,
  input logic [STAT_W-1:0] status_o
);

  logic in_win;
  assign in_win = (fetch_addr_i[ADDR_W-1:WIN_BITS] == '0);

  assert_xlate_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_win |-> fetch_addr_o == {status_o[ADDR_W-1:WIN_BITS], fetch_addr_i[WIN_BITS-1:0]});

  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_win |-> fetch_addr_o == fetch_addr_i);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cmd_trig_i |=> $stable(status_o));

  assert_locked_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_trig_i && boot_q[0]) |=> ($stable(status_o) && fail_o));

  assert_misalign_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_trig_i && tgt_q[WIN_BITS-1:0] != '0) |=> ($stable(status_o) && fail_o));

  assert_done_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_trig_i |=> cmd_done_o);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cmd_trig_i |=> !cmd_done_o);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fail_o && !fail_clr_i) |=> fail_o);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fail_clr_i && !cmd_trig_i) |=> !fail_o);

endmodule

bind vec_remap_ctrl vrm_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS),
  .STAT_W   (STAT_W)
) chk_i (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .boot_q       (boot_q),
  .tgt_q        (tgt_q),
  .fetch_addr_i (fetch_addr_i),
  .fetch_addr_o (fetch_addr_o),
  .cmd_trig_i   (cmd_trig_i),
  .fail_clr_i   (fail_clr_i),
  .cmd_done_o   (cmd_done_o),
  .fail_o       (fail_o),
  .status_o     (status_o)
);

// File: tb/vec_remap_ctrl_tb_top.sv
module vec_remap_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  boot_sel_i;
  logic [23:0] fetch_addr_i;
  logic [23:0] fetch_addr_o;
  logic        tgt_wr_i;
  logic [23:0] tgt_wdata_i;
  logic        cmd_trig_i;
  logic [7:0]  cmd_code_i;
  logic        fail_clr_i;
  logic        cmd_done_o;
  logic        fail_o;
  logic [31:0] status_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [23:0] addr;
    logic [31:0] st;
    logic        fail;
    logic        done;
    string       req;
  } exp_t;

  exp_t sb_q[$];

  // reference model state
  logic [1:0]  m_boot;
  logic [14:0] m_base;
  logic [23:0] m_tgt;
  logic        m_fail;
  logic        m_done;

  vec_remap_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_sel_i   (boot_sel_i),
    .fetch_addr_i (fetch_addr_i),
    .fetch_addr_o (fetch_addr_o),
    .tgt_wr_i     (tgt_wr_i),
    .tgt_wdata_i  (tgt_wdata_i),
    .cmd_trig_i   (cmd_trig_i),
    .cmd_code_i   (cmd_code_i),
    .fail_clr_i   (fail_clr_i),
    .cmd_done_o   (cmd_done_o),
    .fail_o       (fail_o),
    .status_o     (status_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end

  // monitor: compares one expectation per cycle at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks += 4;
      if (fetch_addr_o !== e.addr) begin
        errors++;
        $display("FAIL %s fetch_addr_o got %h expected %h", e.req, fetch_addr_o, e.addr);
      end
      if (status_o !== e.st) begin
        errors++;
        $display("FAIL %s status_o got %h expected %h", e.req, status_o, e.st);
      end
      if (fail_o !== e.fail) begin
        errors++;
        $display("FAIL %s fail_o got %b expected %b", e.req, fail_o, e.fail);
      end
      if (cmd_done_o !== e.done) begin
        errors++;
        $display("FAIL %s cmd_done_o got %b expected %b", e.req, cmd_done_o, e.done);
      end
    end
  end

  task automatic do_reset(input logic [1:0] b);
    @(posedge clk);
    #2;
    rst_n        = 1'b0;
    boot_sel_i   = b;
    fetch_addr_i = '0;
    tgt_wr_i     = 1'b0;
    tgt_wdata_i  = '0;
    cmd_trig_i   = 1'b0;
    cmd_code_i   = '0;
    fail_clr_i   = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst_n  = 1'b1;
    m_boot = b;
    m_base = b[1] ? 15'h0000 : 15'h0800; // R1 reset defaults
    m_tgt  = '0;
    m_fail = 1'b0;
    m_done = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // driver: applies one cycle of stimulus and pushes the expectation
  task automatic step(input logic [23:0] a, input logic wr, input logic [23:0] wd,
                      input logic trg, input logic [7:0] code, input logic clr,
                      input string req);
    exp_t e;
    logic ok;
    @(posedge clk);
    #2;
    fetch_addr_i = a;
    tgt_wr_i     = wr;
    tgt_wdata_i  = wd;
    cmd_trig_i   = trg;
    cmd_code_i   = code;
    fail_clr_i   = clr;
    e.addr = (a[23:9] == '0) ? {m_base, a[8:0]} : a;
    e.st   = {8'h00, m_base, 9'h000};
    e.fail = m_fail;
    e.done = m_done;
    e.req  = req;
    sb_q.push_back(e);
    ok = trg && (code == 8'h2E) && !m_boot[0] && (m_tgt[8:0] == 9'h0);
    if (ok) m_base = m_tgt[23:9];
    m_fail = (trg && !ok) || (m_fail && !clr);
    m_done = trg;
    if (wr) m_tgt = wd;
  endtask

  task automatic fetch(input logic [23:0] a, input string req);
    step(a, 1'b0, '0, 1'b0, 8'h00, 1'b0, req);
  endtask

  task automatic wr_tgt(input logic [23:0] t, input string req);
    step(24'h0, 1'b1, t, 1'b0, 8'h00, 1'b0, req);
  endtask

  task automatic trig(input logic [7:0] code, input logic clr, input string req);
    step(24'h0, 1'b0, '0, 1'b1, code, clr, req);
  endtask

  initial begin
    rst_n = 1'b0;

    // loader ROM with remap
    do_reset(2'b00);
    fetch(24'h0001F0, "R1");
    fetch(24'h000004, "R2");
    fetch(24'h000200, "R3");
    fetch(24'h100004, "R3");
    wr_tgt(24'h000600, "R4");
    trig(8'h2E, 1'b0, "R4");
    fetch(24'h000004, "R4_R7");
    fetch(24'h0001FF, "R7");
    wr_tgt(24'h200000, "R4");
    trig(8'h2E, 1'b0, "R4");
    fetch(24'h0001FF, "R4_R11");
    // misaligned target
    wr_tgt(24'h000610, "R6");
    trig(8'h2E, 1'b0, "R6");
    fetch(24'h000008, "R6");
    fetch(24'h000008, "R8");
    step(24'h0, 1'b0, '0, 1'b0, 8'h00, 1'b1, "R8");
    fetch(24'h000008, "R8");
    // rejection coincides with clear
    trig(8'h2E, 1'b1, "R8");
    fetch(24'h000000, "R8");
    step(24'h0, 1'b0, '0, 1'b0, 8'h00, 1'b1, "R8");
    // unknown command with aligned target
    wr_tgt(24'h000400, "R10");
    trig(8'h2F, 1'b0, "R10");
    fetch(24'h000010, "R10");
    step(24'h0, 1'b0, '0, 1'b0, 8'h00, 1'b1, "R8");
    // back-to-back triggers
    trig(8'h2E, 1'b0, "R7");
    trig(8'h2E, 1'b0, "R7");
    fetch(24'h000020, "R7");
    fetch(24'h000020, "R7");
    // target write in trigger cycle: old target used
    wr_tgt(24'h100000, "R12");
    step(24'h0, 1'b1, 24'h000A00, 1'b1, 8'h2E, 1'b0, "R12");
    fetch(24'h000030, "R12");
    trig(8'h2E, 1'b0, "R12");
    fetch(24'h000030, "R12");

    // application ROM with remap
    do_reset(2'b10);
    fetch(24'h000010, "R1");
    wr_tgt(24'h100000, "R4");
    trig(8'h2E, 1'b0, "R4");
    fetch(24'h000010, "R4");

    // loader ROM, fixed vectors
    do_reset(2'b01);
    fetch(24'h000044, "R1");
    wr_tgt(24'h000800, "R5");
    trig(8'h2E, 1'b0, "R5");
    fetch(24'h000044, "R5");
    step(24'h0, 1'b0, '0, 1'b0, 8'h00, 1'b1, "R8");
    // boot select changed after reset: still locked
    boot_sel_i = 2'b10;
    trig(8'h2E, 1'b0, "R9");
    fetch(24'h000044, "R9");
    fetch(24'h000044, "R9");
    // new reset picks up the changed select
    do_reset(2'b10);
    fetch(24'h000044, "R9");
    // boot select toggled after reset: base unaffected
    boot_sel_i = 2'b01;
    fetch(24'h000044, "R9");

    // application ROM, fixed vectors
    do_reset(2'b11);
    fetch(24'h000100, "R1");
    wr_tgt(24'h100000, "R5");
    trig(8'h2E, 1'b0, "R5");
    fetch(24'h000100, "R5");

    repeat (3) @(posedge clk);
    summary();
    $finish;
  end

endmodule